// File: doc/BRIEF.md
# Mixed-Length Instruction Prefetch Queue

This block is the fetch front end of a small three-stage in-order core whose instructions are 16 or 32 bits wide. It reads 32-bit words from a tightly coupled instruction memory that answers one cycle after each request. It keeps up to three of those words as a queue of six halfword slots. From the head of that queue it presents one complete instruction per cycle to decode, with the instruction's length and its halfword-aligned byte address.

Fetch always assumes a branch is not taken, so it walks through word addresses one after another. When execute reports a taken branch, the queue and any read in flight are thrown away. Fetch restarts at the target's word address in the same cycle. The first target instruction reaches decode two cycles later. A target in the upper half of a word drops the lower halfword of the first word returned. A 32-bit instruction may start in the upper half of one word and finish in the next. It is held back until both halves are queued.

Top module: `ifetch_prefetch`

## Requirements
- R1: A first halfword whose bits [15:11] equal 11101, 11110 or 11111 starts a 32-bit instruction (dec_len32 = 1), and any other value is a 16-bit one. A 32-bit instruction appears on dec_instr with its first halfword in [31:16] and its second in [15:0]. A 16-bit one appears in [15:0], with [31:16] zero. Within a memory word, the lower halfword holds the lower address.
- R2: Instructions are delivered in program order. dec_addr is the halfword-aligned byte address of each one, and it advances by 2 or 4 after each accepted instruction, across word boundaries included.
- R3: The queue never holds more than three words. A read is only issued when the queue will have two free halfword slots once the returning data arrives. With decode stalled from reset, exactly three reads are issued and mem_req then stays low.
- R4: Without a taken branch, each read address (mem_addr while mem_req is high) is the previous one plus 4. The first read after reset is at RESET_ADDR.
- R5: In a cycle where br_taken is high, mem_req is high, mem_addr is br_target with bits [1:0] cleared, and dec_valid is low. Targets are even (bit 0 zero).
- R6: After a taken branch, no instruction fetched before it is delivered. The first instruction delivered has dec_addr equal to the target.
- R7: In the cycle after a taken branch, dec_valid is low. In the second cycle after it, dec_valid is high when the target is word-aligned or its first instruction is 16 bits long.
- R8: For a target with bit 1 set, the lower halfword of the first returned word is discarded. Delivery starts with the upper halfword.
- R9: No partial instruction is ever delivered. While dec_valid is high and dec_ready is low, the same instruction stays on the outputs in the next cycle unless a branch is taken.
- R10: During reset, dec_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | output | 1 | Instruction memory read request |
| mem_addr | output | AW | Word-aligned read byte address |
| mem_rdata | input | 32 | Read data, valid the cycle after a request |
| dec_ready | input | 1 | Decode accepts the presented instruction |
| br_taken | input | 1 | Execute reports a taken branch |
| br_target | input | AW | Byte address of the branch target |
| dec_valid | output | 1 | A complete instruction is presented |
| dec_len32 | output | 1 | Presented instruction is 32 bits long |
| dec_instr | output | 32 | Presented instruction bits |
| dec_addr | output | AW | Byte address of the presented instruction |

## Verification
A memory pattern mixes 16-bit and 32-bit instructions pseudo-randomly, so instructions straddle word boundaries at many offsets. A behavioural model follows the expected program counter and fetch address on every clock. With decode held off from reset, the bench tells a correct fill limit from an overfilled or underfilled queue. Free-running decode exposes throughput and ordering faults, and a randomly stalling decode exposes hold and partial-delivery faults. Branches to word-aligned targets, to upper-halfword targets with short and long first instructions, back-to-back branches and branches under stall separate the flush, refill timing and halfword-skip behaviour.

// File: rtl/ifq_pkg.sv
package ifq_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = 16;

    typedef logic [HALF_W-1:0] hword_t;
    typedef logic [WORD_W-1:0] word_t;

    // Long-form marker: top three bits set and the next two not both zero
    function automatic logic starts_long(hword_t h);
        return (h[15:13] == 3'b111) && (h[12:11] != 2'b00);
    endfunction

endpackage

// File: rtl/ifq_len_dec.sv
module ifq_len_dec
    import ifq_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  hword_t             head0,
    input  hword_t             head1,
    input  logic [CNT_W-1:0]   fill,
    output logic               complete,
    output logic               is32,
    output word_t              instr
);

    always_comb begin
        is32     = starts_long(head0);
        complete = is32 ? (int'(fill) >= 2) : (int'(fill) >= 1);
        instr    = is32 ? {head0, head1} : {16'h0000, head0};
    end

endmodule

// File: rtl/ifq_hw_queue.sv
module ifq_hw_queue
    import ifq_pkg::*;
#(
    parameter int QUEUE_WORDS = 3,
    localparam int SLOTS      = 2 * QUEUE_WORDS,
    localparam int CNT_W      = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic             push_skip,
    input  word_t            push_word,
    input  logic [1:0]       pop_n,
    output hword_t           head0,
    output hword_t           head1,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d
);

    typedef struct packed {
        hword_t [SLOTS-1:0] slot;
        logic [CNT_W-1:0]   cnt;
    } qstate_t;

    qstate_t st_q, st_d;

    always_comb begin
        logic [CNT_W-1:0] wr;
        st_d = st_q;
        // shift out consumed halfwords
        for (int i = 0; i < SLOTS; i++) begin
            int src;
            src = i + int'(pop_n);
            if (src < SLOTS) st_d.slot[i] = st_q.slot[src];
            else             st_d.slot[i] = '0;
        end
        wr = st_q.cnt - CNT_W'(pop_n);
        // append returning word behind what remains
        if (push) begin
            if (push_skip) begin
                if (int'(wr) < SLOTS) st_d.slot[wr] = push_word[31:16];
                wr = wr + CNT_W'(1);
            end else begin
                if (int'(wr) < SLOTS)     st_d.slot[wr] = push_word[15:0];
                if (int'(wr) + 1 < SLOTS) st_d.slot[wr + CNT_W'(1)] = push_word[31:16];
                wr = wr + CNT_W'(2);
            end
        end
        st_d.cnt = flush ? '0 : wr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head0 = st_q.slot[0];
    assign head1 = st_q.slot[1];
    assign cnt_q = st_q.cnt;
    assign cnt_d = st_d.cnt;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush) |-> (int'(cnt_q) - int'(pop_n) + (push_skip ? 1 : 2)) <= SLOTS); // R3
    AST_POP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pop_n) <= int'(cnt_q)); // R9
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/ifq_fetch_ctrl.sv
module ifq_fetch_ctrl #(
    parameter int          AW         = 32,
    parameter logic [AW-1:0] RESET_ADDR = '0,
    parameter int          SLOTS      = 6,
    parameter int          CNT_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             br_taken,
    input  logic [AW-1:0]    br_target,
    input  logic [CNT_W-1:0] q_cnt_d,
    input  logic [1:0]       pop_n,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    output logic             push,
    output logic             push_skip,
    output logic [AW-1:0]    head_addr
);

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [AW-1:0] head;
        logic          inflight;
        logic          skip;
    } cstate_t;

    cstate_t st_q, st_d;
    logic [AW-1:0] tgt_word;

    assign tgt_word  = {br_target[AW-1:2], 2'b00};
    assign push      = st_q.inflight && !br_taken;
    assign push_skip = st_q.skip;
    assign mem_req   = br_taken || (int'(q_cnt_d) <= SLOTS - 2);
    assign mem_addr  = br_taken ? tgt_word : st_q.pc;
    assign head_addr = st_q.head;

    always_comb begin
        st_d = st_q;
        if (br_taken) begin
            st_d.pc       = tgt_word + AW'(4);
            st_d.head     = {br_target[AW-1:1], 1'b0};
            st_d.inflight = 1'b1;
            st_d.skip     = br_target[1];
        end else begin
            if (mem_req) st_d.pc = st_q.pc + AW'(4);
            st_d.head     = st_q.head + AW'({pop_n, 1'b0});
            st_d.inflight = mem_req;
            if (push) st_d.skip = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pc       <= RESET_ADDR;
            st_q.head     <= RESET_ADDR;
            st_q.inflight <= 1'b0;
            st_q.skip     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_TARGET_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> !br_target[0]); // R5
    AST_REDIRECT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |=> (head_addr == {$past(br_target[AW-1:1]), 1'b0})); // R6

endmodule

// File: rtl/ifetch_prefetch.sv
module ifetch_prefetch
    import ifq_pkg::*;
#(
    parameter int            AW          = 32,
    parameter logic [AW-1:0] RESET_ADDR  = 32'h0000_0100,
    parameter int            QUEUE_WORDS = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic [31:0]   mem_rdata,
    input  logic          dec_ready,
    input  logic          br_taken,
    input  logic [AW-1:0] br_target,
    output logic          dec_valid,
    output logic          dec_len32,
    output logic [31:0]   dec_instr,
    output logic [AW-1:0] dec_addr
);

    localparam int SLOTS = 2 * QUEUE_WORDS;
    localparam int CNT_W = $clog2(SLOTS + 1);

    hword_t           head0, head1;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             push, push_skip, complete, is32;
    logic [1:0]       pop_n;
    word_t            instr;

    ifq_hw_queue #(.QUEUE_WORDS(QUEUE_WORDS)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (br_taken),
        .push      (push),
        .push_skip (push_skip),
        .push_word (mem_rdata),
        .pop_n     (pop_n),
        .head0     (head0),
        .head1     (head1),
        .cnt_q     (cnt_q),
        .cnt_d     (cnt_d)
    );

    ifq_len_dec #(.CNT_W(CNT_W)) u_len (
        .head0    (head0),
        .head1    (head1),
        .fill     (cnt_q),
        .complete (complete),
        .is32     (is32),
        .instr    (instr)
    );

    ifq_fetch_ctrl #(
        .AW         (AW),
        .RESET_ADDR (RESET_ADDR),
        .SLOTS      (SLOTS),
        .CNT_W      (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .br_taken  (br_taken),
        .br_target (br_target),
        .q_cnt_d   (cnt_d),
        .pop_n     (pop_n),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .push      (push),
        .push_skip (push_skip),
        .head_addr (dec_addr)
    );

    assign dec_valid = complete && !br_taken;
    assign dec_len32 = is32;
    assign dec_instr = instr;
    assign pop_n     = (dec_valid && dec_ready) ? (is32 ? 2'd2 : 2'd1) : 2'd0;

    AST_REFILL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(br_taken) |-> !dec_valid); // R7
    AST_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dec_valid && dec_ready) && !$past(br_taken) && dec_valid) |->
        (dec_addr == $past(dec_addr) + ($past(dec_len32) ? AW'(4) : AW'(2)))); // R2
    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dec_valid && !dec_ready) && !br_taken) |->
        (dec_valid && $stable(dec_instr) && $stable(dec_addr))); // R9

endmodule

// File: tb/sim_ifetch_prefetch.sv
`timescale 1ns/1ps
module sim_ifetch_prefetch;

    localparam logic [31:0] RST_A = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        dec_ready = 1'b0;
    logic        br_taken = 1'b0;
    logic [31:0] br_target = '0;
    logic        dec_valid, dec_len32;
    logic [31:0] dec_instr, dec_addr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ifetch_prefetch #(.AW(32), .RESET_ADDR(RST_A), .QUEUE_WORDS(3)) u0 (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .dec_ready(dec_ready), .br_taken(br_taken),
        .br_target(br_target), .dec_valid(dec_valid), .dec_len32(dec_len32),
        .dec_instr(dec_instr), .dec_addr(dec_addr)
    );

    // program image: pseudo-random mix of short and long encodings
    function automatic logic [15:0] hw_at(input logic [31:0] a);
        logic [31:0] x;
        logic [4:0]  top;
        x = a * 32'h9E37_79B1;
        x = x ^ (x >> 13);
        if (x[3:0] < 4'd6) begin
            case (x[5:4])
                2'd0:    top = 5'b11101;
                2'd1:    top = 5'b11110;
                default: top = 5'b11111;
            endcase
        end else begin
            top = x[12:8];
            if (top >= 5'b11101) top = 5'b11100;
        end
        return {top, x[26:16]};
    endfunction

    function automatic bit long_hw(input logic [15:0] h);
        return (h[15:11] == 5'b11101) || (h[15:11] == 5'b11110) || (h[15:11] == 5'b11111);
    endfunction

    function automatic logic [31:0] find_tgt(input logic [31:0] start, input bit upper, input bit want32);
        logic [31:0] a;
        a = {start[31:2], upper, 1'b0};
        for (int k = 0; k < 2000; k++) begin
            if (long_hw(hw_at(a)) == want32) return a;
            a = a + 32'd4;
        end
        return a;
    endfunction

    // single-cycle memory
    always @(posedge clk) begin
        if (mem_req) mem_rdata <= {hw_at(mem_addr + 32'd2), hw_at(mem_addr)};
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model state
    logic [31:0] exp_fetch = RST_A;
    logic [31:0] exp_pc = RST_A;
    logic [31:0] last_tgt = '0;
    bit          last_bt = 0;
    bit          first_after = 0;
    int          since = 3;
    bit          last_req = 0;
    bit          prev_hold = 0;
    logic [31:0] prev_instr = '0;

    task automatic cyc(input bit rdy, input bit bt, input logic [31:0] tgt);
        logic [31:0] e_instr;
        bit          e_long;
        @(negedge clk);
        rst_n = 1'b1;
        dec_ready = rdy;
        br_taken = bt;
        br_target = tgt;
        #1;
        if (last_bt) since = 1;
        else if (since > 0 && since < 3) since++;
        last_req = mem_req;
        if (bt) begin
            chk(mem_req === 1'b1 && mem_addr === {tgt[31:2], 2'b00}, "R5", mem_addr, {tgt[31:2], 2'b00});
            chk(dec_valid === 1'b0, "R5", {31'd0, dec_valid}, 32'd0);
            exp_fetch = {tgt[31:2], 2'b00} + 32'd4;
            exp_pc = {tgt[31:1], 1'b0};
            last_tgt = exp_pc;
            first_after = 1;
            since = 0;
            prev_hold = 0;
        end else begin
            if (mem_req) begin
                chk(mem_addr === exp_fetch, "R4", mem_addr, exp_fetch);
                exp_fetch = exp_fetch + 32'd4;
            end
            if (since == 1) chk(dec_valid === 1'b0, "R7", {31'd0, dec_valid}, 32'd0);
            if (since == 2 && (!last_tgt[1] || !long_hw(hw_at(last_tgt))))
                chk(dec_valid === 1'b1, "R7", {31'd0, dec_valid}, 32'd1);
            if (prev_hold) begin
                chk(dec_valid === 1'b1 && dec_instr === prev_instr, "R9", dec_instr, prev_instr);
            end
            if (dec_valid) begin
                e_long = long_hw(hw_at(exp_pc));
                e_instr = e_long ? {hw_at(exp_pc), hw_at(exp_pc + 32'd2)} : {16'h0000, hw_at(exp_pc)};
                chk(dec_len32 === e_long, "R1", {31'd0, dec_len32}, {31'd0, e_long});
                chk(dec_instr === e_instr, "R1", dec_instr, e_instr);
                if (first_after)
                    chk(dec_addr === exp_pc, last_tgt[1] ? "R8" : "R6", dec_addr, exp_pc);
                else
                    chk(dec_addr === exp_pc, "R2", dec_addr, exp_pc);
                if (rdy) begin
                    exp_pc = exp_pc + (e_long ? 32'd4 : 32'd2);
                    first_after = 0;
                end
            end
            prev_hold = dec_valid && !rdy;
            prev_instr = dec_instr;
        end
        last_bt = bt;
    endtask

    task automatic run(input int n, input bit rdy);
        for (int i = 0; i < n; i++) cyc(rdy, 0, '0);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int nreq;
        logic [31:0] t, t2, lfsr;
        repeat (4) @(negedge clk);
        #1;
        chk(dec_valid === 1'b0, "R10", {31'd0, dec_valid}, 32'd0);

        // decode stalled from reset: fill limit
        nreq = 0;
        for (int i = 0; i < 12; i++) begin
            cyc(0, 0, '0);
            if (last_req) nreq++;
        end
        chk(nreq == 3, "R3", nreq, 32'd3);
        chk(mem_req === 1'b0, "R3", {31'd0, mem_req}, 32'd0);

        run(80, 1);

        // word-aligned target
        t = find_tgt(32'h0000_2000, 0, 1);
        cyc(1, 1, t); run(30, 1);
        // upper-halfword target, short first instruction
        t = find_tgt(32'h0000_3000, 1, 0);
        cyc(1, 1, t); run(30, 1);
        // upper-halfword target, long first instruction split across words
        t = find_tgt(32'h0000_4000, 1, 1);
        cyc(1, 1, t); run(30, 1);
        // branch while decode stalled
        run(5, 0);
        t = find_tgt(32'h0000_5000, 1, 1);
        cyc(0, 1, t); run(8, 0); run(20, 1);
        // back-to-back branches
        t = find_tgt(32'h0000_6000, 0, 0);
        t2 = find_tgt(32'h0000_7000, 1, 0);
        cyc(1, 1, t); cyc(1, 1, t2); run(20, 1);
        // branch two cycles after another
        cyc(1, 1, t); run(1, 1); cyc(1, 1, t2); run(20, 1);

        // random stalls and branches
        lfsr = 32'hACE1_2345;
        for (int i = 0; i < 1500; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (lfsr[9:4] == 6'd0)
                cyc(lfsr[2], 1, {16'h0000, lfsr[27:14], 2'b00} | {30'd0, lfsr[3], 1'b0});
            else
                cyc(lfsr[2] | lfsr[11], 0, '0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule